// File: doc/BRIEF.md
# External Bus Area Cycle Controller

This block runs external bus cycles for two 64 MB memory areas on a 32-bit physical address. The area comes from three upper address bits. Each area has its own configuration inputs. One input picks between a plain memory cycle (chip select, read enable, per-lane write enables) and a card cycle (low and high card enables with card output or write enable). In card mode the upper half of the high area is a separate I/O window that uses its own read and write strobes. Every access has three phases: an address setup, a strobe phase whose length is programmed and can be stretched by an external WAIT pin, and an address hold.

The block runs on a clock at twice the external bus rate, so one clock is half a bus cycle. Setup and hold therefore come out in half-cycle steps. Requests arrive on a valid/ready channel. `req_ready` is high only while the sequencer is idle, so the requester is held off for the whole external cycle. Each accepted request produces exactly one response on a second valid/ready channel. The response waits, with its error flag unchanged, until `rsp_ready` is seen. No new request is accepted before the response has been taken.

Top module: `xbus_area_ctrl`

## Requirements
- R1: Address bits [28:26] equal to 3'b101 select the low area (index 0) and 3'b110 select the high area (index 1). Bits [31:29] have no effect, so every 512 MB alias reaches the same area with identical strobes.
- R2: A request whose bits [28:26] match neither area is answered with `rsp_err`=1 in the clock after acceptance. No enable or strobe is driven for it.
- R3: A request is answered with an error and drives no pins in three cases. The first is a request wider than the area's port; request size 0=byte, 1=word, 2 or 3=longword. The second is a longword request to a card-mode area. The third is a card-mode access to the low area with address bit 25 set.
- R4: Plain mode uses `cfg_width` per area: 0=byte, 1=word, 2 or 3=longword. The area's `cs_area` bit is held through all three phases. During the strobe phase a read drives `rd_oe`, and a write drives `we_lane` equal to `req_be` masked to the port lanes (byte: lane 0, word: lanes 0-1, longword: all four).
- R5: Card mode uses `cfg_width` 0=byte and any other value=word. In the card memory space the area's `card_ce1`/`card_ce2` bits are held through all three phases. `card_ce1` is set for a byte port or when lane 0 is enabled. `card_ce2` is set only for a word port with lane 1 enabled. During the strobe phase `card_oe` is driven on reads and `card_we` on writes.
- R6: In card mode, high-area addresses with bit 25 set drive `io_rd` or `io_wr` in place of `card_oe`/`card_we`. At most one strobe kind is ever active at a time.
- R7: Enables and `bus_addr` lead the strobe by 2*S+1 clocks, where S is the area's 2-bit setup field. `bus_addr` is stable while any enable is active.
- R8: With no WAIT, the strobe lasts 2*W+2 clocks. The 3-bit wait code maps to W as codes 0-4 map to 0-4, code 5 to 6, code 6 to 8 and code 7 to 10.
- R9: `ext_wait` is sampled only once the programmed strobe length has elapsed. While it is high after that point, the strobe continues, and it ends at the first clock edge where it is low.
- R10: After the strobe falls, the enables stay active for 2*H+1 clocks, where H is the area's 2-bit hold field, and then drop. The response follows in the next clock.
- R11: After reset, `req_ready`=1, `rsp_valid`=0 and no enable is active. `req_ready` is low from acceptance until the response is taken. A response not taken holds `rsp_valid` and `rsp_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the external bus rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 32 | Physical byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2/3 longword |
| req_be | input | 4 | Byte lane enables |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken on this edge when valid |
| rsp_err | output | 1 | Request was rejected |
| cfg_card | input | 2 | Per area: 1 = card mode |
| cfg_width | input | 4 | Per area 2-bit port width, area 0 in [1:0] |
| cfg_wait | input | 6 | Per area 3-bit wait code, area 0 in [2:0] |
| cfg_setup | input | 4 | Per area 2-bit setup field |
| cfg_hold | input | 4 | Per area 2-bit hold field |
| ext_wait | input | 1 | External wait request, active high |
| bus_addr | output | 32 | Latched external address |
| cs_area | output | 2 | Plain-mode chip select per area |
| rd_oe | output | 1 | Plain-mode read / output enable |
| we_lane | output | 4 | Plain-mode per-lane write enables |
| card_ce1 | output | 2 | Card low-byte enable per area |
| card_ce2 | output | 2 | Card high-byte enable per area |
| card_oe | output | 1 | Card memory read strobe |
| card_we | output | 1 | Card memory write strobe |
| io_rd | output | 1 | Card I/O read strobe |
| io_wr | output | 1 | Card I/O write strobe |

## Verification
The hardest case to reach from the ports is the edge between the programmed strobe length and the WAIT extension. If WAIT is released one clock too early, nothing changes; if it is released one clock later, the strobe grows by one clock. To reach that edge, the driver asserts `ext_wait` together with the request and releases it a counted number of edges after the acceptance edge. It uses release points before, exactly at, and past the end of the programmed length, and the expected strobe width is the larger of the programmed length and the release point minus the setup. A held response is produced by lowering `rsp_ready` before a request and raising it several clocks after `rsp_valid` appears.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int LANES    = 4;
  localparam int WCODE_W  = 3;
  localparam int TSEL_W   = 2;
  localparam int MAX_WAIT = 10;
  localparam int CNT_W    = $clog2(2 * MAX_WAIT + 2);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_RESP
  } seq_state_t;

  typedef enum logic [1:0] {
    K_NONE,
    K_MEM,
    K_CARD_MEM,
    K_CARD_IO
  } cyc_kind_t;

  typedef struct packed {
    logic               err;
    logic               area_hi;
    cyc_kind_t          kind;
    logic               write;
    logic [LANES-1:0]   lanes;
    logic               ce1;
    logic               ce2;
    logic [TSEL_W-1:0]  setup;
    logic [TSEL_W-1:0]  hold;
    logic [WCODE_W-1:0] wcode;
  } cyc_desc_t;

  // Wait code to wait cycles: linear up to 4, then steps of two up to the cap.
  function automatic logic [CNT_W-1:0] wait_cycles(input logic [WCODE_W-1:0] code);
    logic [CNT_W-1:0] r;
    case (code)
      3'd5:    r = CNT_W'(6);
      3'd6:    r = CNT_W'(8);
      3'd7:    r = CNT_W'(MAX_WAIT);
      default: r = CNT_W'(code);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/xbus_decode.sv
module xbus_decode
  import xbus_pkg::*;
#(
  parameter logic [2:0] SEL_LO = 3'b101,
  parameter logic [2:0] SEL_HI = 3'b110
) (
  input  logic [3:0]            addr_hi4,
  input  logic                  write,
  input  logic [1:0]            size,
  input  logic [LANES-1:0]      be,
  input  logic [1:0]            cfg_card,
  input  logic [3:0]            cfg_width,
  input  logic [2*WCODE_W-1:0]  cfg_wait,
  input  logic [2*TSEL_W-1:0]   cfg_setup,
  input  logic [2*TSEL_W-1:0]   cfg_hold,
  output cyc_desc_t             desc
);
  logic [2:0]       sel;
  logic             hit_lo, hit_hi, card, half;
  logic [1:0]       wf, port_w, need_w;
  logic [LANES-1:0] pmask;

  always_comb begin
    sel    = addr_hi4[3:1];
    half   = addr_hi4[0];
    hit_lo = (sel == SEL_LO);
    hit_hi = (sel == SEL_HI);
    card   = hit_hi ? cfg_card[1] : cfg_card[0];
    wf     = hit_hi ? cfg_width[3:2] : cfg_width[1:0];
    if (card) port_w = (wf == 2'b00) ? 2'd0 : 2'd1;
    else      port_w = wf[1] ? 2'd2 : {1'b0, wf[0]};
    need_w = size[1] ? 2'd2 : {1'b0, size[0]};
    case (port_w)
      2'd0:    pmask = LANES'(4'b0001);
      2'd1:    pmask = LANES'(4'b0011);
      default: pmask = '1;
    endcase

    desc         = '0;
    desc.err     = !(hit_lo || hit_hi) || (need_w > port_w) || (card && hit_lo && half);
    desc.area_hi = hit_hi;
    desc.write   = write;
    if (desc.err)             desc.kind = K_NONE;
    else if (!card)           desc.kind = K_MEM;
    else if (hit_hi && half)  desc.kind = K_CARD_IO;
    else                      desc.kind = K_CARD_MEM;
    desc.lanes = be & pmask;
    desc.ce1   = card && ((port_w == 2'd0) || be[0]);
    desc.ce2   = card && (port_w == 2'd1) && be[1];
    desc.setup = hit_hi ? cfg_setup[2*TSEL_W-1:TSEL_W] : cfg_setup[TSEL_W-1:0];
    desc.hold  = hit_hi ? cfg_hold[2*TSEL_W-1:TSEL_W]  : cfg_hold[TSEL_W-1:0];
    desc.wcode = hit_hi ? cfg_wait[2*WCODE_W-1:WCODE_W] : cfg_wait[WCODE_W-1:0];
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  cyc_desc_t         desc_in,
  input  logic              ext_wait,
  input  logic              rsp_ready,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_err,
  output seq_state_t        state,
  output cyc_desc_t         cur,
  output logic [ADDR_W-1:0] addr_q
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] wt;
  logic [CNT_W-1:0] setup_end, strobe_end, hold_end;

  // Phase ends in half bus cycles: odd for setup and hold, even length for the strobe.
  assign wt         = wait_cycles(cur.wcode);
  assign setup_end  = CNT_W'({cur.setup, 1'b0});
  assign strobe_end = {wt[CNT_W-2:0], 1'b1};
  assign hold_end   = CNT_W'({cur.hold, 1'b0});

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_err   = cur.err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      cur    <= '0;
      addr_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur <= desc_in;
            cnt <= '0;
            if (desc_in.err) begin
              state <= ST_RESP;
            end else begin
              addr_q <= req_addr;
              state  <= ST_SETUP;
            end
          end
        end
        ST_SETUP: begin
          if (cnt == setup_end) begin
            cnt   <= '0;
            state <= ST_STROBE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STROBE: begin
          if (cnt != strobe_end) begin
            cnt <= cnt + 1'b1;
          end else if (!ext_wait) begin
            cnt   <= '0;
            state <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (cnt == hold_end) state <= ST_RESP;
          else                 cnt   <= cnt + 1'b1;
        end
        ST_RESP: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
(
  input  seq_state_t       state,
  input  logic             area_hi,
  input  cyc_kind_t        kind,
  input  logic             write,
  input  logic [LANES-1:0] lanes,
  input  logic             ce1,
  input  logic             ce2,
  output logic [1:0]       cs_area,
  output logic             rd_oe,
  output logic [LANES-1:0] we_lane,
  output logic [1:0]       card_ce1,
  output logic [1:0]       card_ce2,
  output logic             card_oe,
  output logic             card_we,
  output logic             io_rd,
  output logic             io_wr
);
  logic busy, strb, is_card;

  assign busy    = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign strb    = (state == ST_STROBE);
  assign is_card = (kind == K_CARD_MEM) || (kind == K_CARD_IO);

  for (genvar a = 0; a < 2; a++) begin : g_area
    logic mine;
    assign mine        = busy && (area_hi == 1'(a));
    assign cs_area[a]  = mine && (kind == K_MEM);
    assign card_ce1[a] = mine && is_card && ce1;
    assign card_ce2[a] = mine && is_card && ce2;
  end

  assign rd_oe   = strb && (kind == K_MEM) && !write;
  assign we_lane = (strb && (kind == K_MEM) && write) ? lanes : '0;
  assign card_oe = strb && (kind == K_CARD_MEM) && !write;
  assign card_we = strb && (kind == K_CARD_MEM) && write;
  assign io_rd   = strb && (kind == K_CARD_IO) && !write;
  assign io_wr   = strb && (kind == K_CARD_IO) && write;
endmodule

// File: rtl/xbus_area_ctrl.sv
module xbus_area_ctrl
  import xbus_pkg::*;
#(
  parameter int         ADDR_W  = 32,
  parameter int         SEL_LSB = 26,
  parameter logic [2:0] SEL_LO  = 3'b101,
  parameter logic [2:0] SEL_HI  = 3'b110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [3:0]        req_be,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err,
  input  logic [1:0]        cfg_card,
  input  logic [3:0]        cfg_width,
  input  logic [5:0]        cfg_wait,
  input  logic [3:0]        cfg_setup,
  input  logic [3:0]        cfg_hold,
  input  logic              ext_wait,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        cs_area,
  output logic              rd_oe,
  output logic [3:0]        we_lane,
  output logic [1:0]        card_ce1,
  output logic [1:0]        card_ce2,
  output logic              card_oe,
  output logic              card_we,
  output logic              io_rd,
  output logic              io_wr
);
  localparam int HALF_BIT = SEL_LSB - 1;

  cyc_desc_t  desc, cur;
  seq_state_t state;

  xbus_decode #(.SEL_LO(SEL_LO), .SEL_HI(SEL_HI)) u_dec (
    .addr_hi4  (req_addr[SEL_LSB+2:HALF_BIT]),
    .write     (req_write),
    .size      (req_size),
    .be        (req_be),
    .cfg_card  (cfg_card),
    .cfg_width (cfg_width),
    .cfg_wait  (cfg_wait),
    .cfg_setup (cfg_setup),
    .cfg_hold  (cfg_hold),
    .desc      (desc)
  );

  xbus_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .desc_in   (desc),
    .ext_wait  (ext_wait),
    .rsp_ready (rsp_ready),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .state     (state),
    .cur       (cur),
    .addr_q    (bus_addr)
  );

  xbus_pins u_pins (
    .state    (state),
    .area_hi  (cur.area_hi),
    .kind     (cur.kind),
    .write    (cur.write),
    .lanes    (cur.lanes),
    .ce1      (cur.ce1),
    .ce2      (cur.ce2),
    .cs_area  (cs_area),
    .rd_oe    (rd_oe),
    .we_lane  (we_lane),
    .card_ce1 (card_ce1),
    .card_ce2 (card_ce2),
    .card_oe  (card_oe),
    .card_we  (card_we),
    .io_rd    (io_rd),
    .io_wr    (io_wr)
  );
endmodule

// File: rtl/xbus_area_ctrl_chk.sv
module xbus_area_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_err,
  input logic [31:0] bus_addr,
  input logic [1:0]  cs_area,
  input logic        rd_oe,
  input logic [3:0]  we_lane,
  input logic [1:0]  card_ce1,
  input logic [1:0]  card_ce2,
  input logic        card_oe,
  input logic        card_we,
  input logic        io_rd,
  input logic        io_wr
);
  logic any_en, any_st;
  assign any_en = (|cs_area) || (|card_ce1) || (|card_ce2);
  assign any_st = rd_oe || (|we_lane) || card_oe || card_we || io_rd || io_wr;

  // R10: a strobe never appears outside the enable window
  assert_strobe_in_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    any_st |-> any_en);

  // R10: enables outlive the strobe by at least one clock
  assert_hold_after_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_st) |-> any_en);

  // R2: nothing is driven while a response is presented
  assert_quiet_on_response_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !any_en && !any_st);

  // R11: an untaken response stays with the same error flag
  assert_rsp_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_err));

  // R11: no acceptance while a response is pending or a cycle runs
  assert_no_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || any_en) |-> !req_ready);

  // R1: only one area is ever enabled
  assert_single_area_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_area, card_ce1[0] || card_ce2[0], card_ce1[1] || card_ce2[1]}));

  // R6: one strobe kind at a time
  assert_one_strobe_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_oe, |we_lane, card_oe, card_we, io_rd, io_wr}));

  // R7: address stable during the enable window
  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_en && $past(any_en) |-> $stable(bus_addr));

  // R8: strobe is at least one full bus cycle
  assert_min_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_st) |=> any_st);
endmodule

bind xbus_area_ctrl xbus_area_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_err   (rsp_err),
  .bus_addr  (bus_addr),
  .cs_area   (cs_area),
  .rd_oe     (rd_oe),
  .we_lane   (we_lane),
  .card_ce1  (card_ce1),
  .card_ce2  (card_ce2),
  .card_oe   (card_oe),
  .card_we   (card_we),
  .io_rd     (io_rd),
  .io_wr     (io_wr)
);

// File: tb/xbus_area_ctrl_test.sv
`timescale 1ns/1ps
module xbus_area_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [3:0]  req_be = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_err;
  logic [1:0]  cfg_card = '0;
  logic [3:0]  cfg_width = '0;
  logic [5:0]  cfg_wait = '0;
  logic [3:0]  cfg_setup = '0;
  logic [3:0]  cfg_hold = '0;
  logic        ext_wait = 1'b0;
  logic [31:0] bus_addr;
  logic [1:0]  cs_area;
  logic        rd_oe;
  logic [3:0]  we_lane;
  logic [1:0]  card_ce1, card_ce2;
  logic        card_oe, card_we, io_rd, io_wr;

  always #4 clk = ~clk;

  xbus_area_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_size(req_size), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .cfg_card(cfg_card), .cfg_width(cfg_width), .cfg_wait(cfg_wait),
    .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .ext_wait(ext_wait),
    .bus_addr(bus_addr), .cs_area(cs_area), .rd_oe(rd_oe), .we_lane(we_lane),
    .card_ce1(card_ce1), .card_ce2(card_ce2), .card_oe(card_oe), .card_we(card_we),
    .io_rd(io_rd), .io_wr(io_wr)
  );

  typedef struct {
    string       tag;
    bit          err;
    logic [14:0] sig;
    int          su, sw, ho;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Expected item built from the requirement text only.
  function automatic exp_t model(input logic [31:0] a, input bit w, input logic [1:0] sz,
                                 input logic [3:0] be, input int t, input string tag);
    exp_t e;
    bit hi, hit, card, io, c1, c2;
    int portb, needb, s, h, wc, wn;
    logic [3:0] pm, lanes;
    logic [1:0] cs, ce1, ce2;
    e.tag = tag; e.sig = '0; e.su = 0; e.sw = 0; e.ho = 0;
    hi  = (a[28:26] == 3'b110);
    hit = hi || (a[28:26] == 3'b101);
    card = hi ? cfg_card[1] : cfg_card[0];
    wc   = hi ? int'(cfg_width[3:2]) : int'(cfg_width[1:0]);
    if (card) portb = (wc == 0) ? 1 : 2;
    else      portb = (wc == 0) ? 1 : (wc == 1) ? 2 : 4;
    needb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    e.err = !hit || (needb > portb) || (card && !hi && a[25]);
    if (!e.err) begin
      s  = hi ? int'(cfg_setup[3:2]) : int'(cfg_setup[1:0]);
      h  = hi ? int'(cfg_hold[3:2])  : int'(cfg_hold[1:0]);
      wc = hi ? int'(cfg_wait[5:3])  : int'(cfg_wait[2:0]);
      wn = (wc < 5) ? wc : (wc == 5) ? 6 : (wc == 6) ? 8 : 10;
      e.su = 2*s + 1;
      e.ho = 2*h + 1;
      e.sw = 2*wn + 2;
      if (t > 0 && t - 2*s > e.sw) e.sw = t - 2*s;
      pm = (portb == 1) ? 4'b0001 : (portb == 2) ? 4'b0011 : 4'b1111;
      lanes = be & pm;
      io = card && hi && a[25];
      c1 = card && (portb == 1 || be[0]);
      c2 = card && portb == 2 && be[1];
      cs  = card ? 2'b00 : (hi ? 2'b10 : 2'b01);
      ce1 = c1 ? (hi ? 2'b10 : 2'b01) : 2'b00;
      ce2 = c2 ? (hi ? 2'b10 : 2'b01) : 2'b00;
      e.sig = {cs, ce1, ce2, !card && !w, (!card && w) ? lanes : 4'b0000,
               card && !io && !w, card && !io && w, io && !w, io && w};
    end
    return e;
  endfunction

  task automatic run(input logic [31:0] a, input bit w, input logic [1:0] sz,
                     input logic [3:0] be, input int t, input string tag);
    q.push_back(model(a, w, sz, be, t, tag));
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr = a; req_write = w; req_size = sz; req_be = be; req_valid = 1'b1;
    if (t > 0) ext_wait = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    if (t > 0) begin
      repeat (t) @(posedge clk);
      #1 ext_wait = 1'b0;
    end
  endtask

  // Monitor: measure each cycle's phases and pins, compare at the response transfer.
  int m_su = 0, m_sw = 0, m_ho = 0;
  bit seen = 0;
  logic [14:0] sig = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit en = (|cs_area) || (|card_ce1) || (|card_ce2);
      automatic bit st = rd_oe || (|we_lane) || card_oe || card_we || io_rd || io_wr;
      sig = sig | {cs_area, card_ce1, card_ce2, rd_oe, we_lane, card_oe, card_we, io_rd, io_wr};
      if (st) begin seen = 1; m_sw++; end
      else if (en && !seen) m_su++;
      else if (en && seen) m_ho++;
      if (rsp_valid && rsp_ready) begin
        if (q.size() == 0) begin
          chk(0, "R11", "response without request", 1, 0);
        end else begin
          automatic exp_t e = q.pop_front();
          chk(rsp_err == e.err, e.tag, "error flag", int'(rsp_err), int'(e.err));
          chk(sig == e.sig, e.tag, "pin set", int'(sig), int'(e.sig));
          chk(m_su == e.su, e.tag, "setup clocks", m_su, e.su);
          chk(m_sw == e.sw, e.tag, "strobe clocks", m_sw, e.sw);
          chk(m_ho == e.ho, e.tag, "hold clocks", m_ho, e.ho);
        end
        m_su = 0; m_sw = 0; m_ho = 0; seen = 0; sig = '0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: got %0d pending expected 0", q.size());
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(req_ready == 1'b1, "R11", "ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R11", "rsp_valid after reset", int'(rsp_valid), 0);
    chk({cs_area, card_ce1, card_ce2} == 6'b0, "R11", "enables after reset",
        int'({cs_area, card_ce1, card_ce2}), 0);

    // Plain mode: area 0 longword, area 1 word
    cfg_card = 2'b00; cfg_width = 4'b01_10; cfg_wait = 6'b011_000;
    cfg_setup = 4'b10_00; cfg_hold = 4'b01_00;
    run(32'h1400_0100, 0, 2'd2, 4'b1111, 0, "R4");
    run(32'h1400_0200, 1, 2'd1, 4'b0011, 0, "R4");
    run(32'hF400_0000, 0, 2'd2, 4'b1111, 0, "R1");
    run(32'h3400_0010, 1, 2'd0, 4'b0100, 0, "R1");
    run(32'hB800_0000, 1, 2'd1, 4'b1111, 0, "R4");
    run(32'h1800_0000, 0, 2'd2, 4'b1111, 0, "R3");
    run(32'h1000_0000, 0, 2'd0, 4'b0001, 0, "R2");
    run(32'h1C00_0000, 1, 2'd0, 4'b0001, 0, "R2");

    // R7 R10: largest setup and hold
    cfg_setup = 4'b10_11; cfg_hold = 4'b01_11;
    run(32'h1400_0040, 0, 2'd0, 4'b0001, 0, "R7");
    // R8: wait code map at the top
    cfg_setup = 4'b10_00; cfg_hold = 4'b01_00; cfg_wait = 6'b011_111;
    run(32'h1400_0000, 0, 2'd2, 4'b1111, 0, "R8");
    cfg_wait = 6'b011_101;
    run(32'h1400_0000, 1, 2'd2, 4'b1111, 0, "R8");

    // R9: WAIT released before, at and after the programmed length (S=1, W=1)
    cfg_wait = 6'b011_001; cfg_setup = 4'b10_01;
    run(32'h1400_0000, 0, 2'd0, 4'b0001, 5, "R9");
    run(32'h1400_0000, 0, 2'd0, 4'b0001, 6, "R9");
    run(32'h1400_0000, 0, 2'd0, 4'b0001, 7, "R9");
    run(32'h1400_0000, 0, 2'd0, 4'b0001, 20, "R9");

    // Card mode: area 0 word port, area 1 byte port
    @(negedge clk); while (q.size() != 0) @(negedge clk);
    cfg_card = 2'b11; cfg_width = 4'b00_01; cfg_wait = 6'b010_001;
    cfg_setup = 4'b01_01; cfg_hold = 4'b10_00;
    run(32'h1400_0000, 0, 2'd1, 4'b0011, 0, "R5");
    run(32'h1400_0001, 1, 2'd0, 4'b0010, 0, "R5");
    run(32'h1600_0000, 0, 2'd0, 4'b0001, 0, "R3");
    run(32'h1400_0000, 0, 2'd2, 4'b1111, 0, "R3");
    run(32'h1A00_0000, 0, 2'd0, 4'b0001, 0, "R6");
    run(32'h7A00_0001, 1, 2'd0, 4'b0010, 0, "R6");
    run(32'h1800_0004, 1, 2'd0, 4'b0001, 0, "R5");
    cfg_width = 4'b11_01;
    run(32'h1800_0000, 0, 2'd2, 4'b1111, 0, "R3");
    run(32'h1800_0000, 0, 2'd1, 4'b0011, 0, "R5");

    // R11: response held under back-pressure
    @(negedge clk); while (q.size() != 0) @(negedge clk);
    rsp_ready = 1'b0;
    run(32'h1000_0000, 0, 2'd0, 4'b0001, 0, "R11");
    @(negedge clk); while (!rsp_valid) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_err && !req_ready, "R11", "held response",
          int'({rsp_valid, rsp_err, req_ready}), 3'b110);
    end
    @(posedge clk);
    #1 rsp_ready = 1'b1;
    run(32'h1400_0000, 0, 2'd1, 4'b0011, 0, "R11");

    @(negedge clk);
    while (q.size() != 0 || !req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule